// File: doc/BRIEF.md
# Block Transfer Controller Register Target

This block is the software-facing register file of a simple block-transfer controller. It holds nine 32-bit registers in a 36-byte window behind a request/response target port. Software programs a memory buffer address, how many blocks to move and the first block index. It then writes an operation code, which launches the transfer engine with a one-cycle go pulse. The engine reports completion and failure back on two plain inputs. The block turns that report into a completion status and, when software has enabled it, an interrupt.

Each register sits at a fixed word offset, shown in the table below. Offsets 0x24 and up, and any address that is not word aligned, are outside the window.

| Offset | Register | Access | Reset value |
|--------|----------|--------|-------------|
| 0x00 | buffer address, low word | read/write | 0 |
| 0x04 | block count | read/write | 0 |
| 0x08 | first block index | read/write | 0 |
| 0x0C | operation | write only | none (not stored) |
| 0x10 | status | read only | 0 (idle) |
| 0x14 | interrupt enable | read/write | 0 |
| 0x18 | device size in blocks (`dev_blocks` input) | read only | input value |
| 0x1C | block size in bytes (`BLOCK_BYTES` parameter) | read only | parameter value |
| 0x20 | buffer address, high word (`ext_base_hi` input) | read only | input value |

The request and the response are both valid/ready streams.
- A request moves on a cycle where `req_valid` and `req_ready` are both high.
- The response appears registered in the next cycle, holding its data and code.
- The response stays stable until a cycle where `rsp_valid` and `rsp_ready` are both high.
- Only one request is outstanding at a time. `req_ready` stays low while a response waits, so a stalled `rsp_ready` back-pressures the request side.

The engine-side pins carry no handshake. They are plain control and status pins.

Top module: `blkdev_regs`

## Requirements
- R1: After reset:
  - the four read/write registers read zero and the status reads idle (0);
  - `irq` and `xfer_go` are low;
  - `rsp_valid` is low and `req_ready` is high.
- R2: Offsets 0x00 (buffer low), 0x04 (block count), 0x08 (first block) and 0x14 (interrupt enable) read back the last value written.
  - A read answers with response code 0 (read OK).
  - A write answers with response code 2 (write OK).
- R3: Writing operation offset 0x0C while the status is idle with value 1 or value 2 starts a transfer.
  - Value 1 moves data from the device to memory; value 2 moves data from memory to the device.
  - `xfer_go` is high for exactly the one cycle after the write is accepted, and `xfer_to_mem` is 1 for value 1 and 0 for value 2.
  - The status becomes busy (1).
  - Any other value, including 0, starts nothing, leaves the status unchanged and answers write OK.
- R4: A read of offset 0x0C returns data 0 with response code 1 (read error).
- R5: Writes to offsets 0x10, 0x18, 0x1C and 0x20 answer response code 3 (write error) and change nothing.
- R6: The read-only values are reported as follows:
  - offset 0x18 returns `dev_blocks`;
  - offset 0x1C returns `BLOCK_BYTES`;
  - offset 0x20 returns `ext_base_hi`;
  - `xfer_buf` presents `ext_base_hi` above the buffer low word.
- R7: While busy, an `eng_done` pulse sets the status as follows.
  - Without `eng_err`: 2 (device-to-memory done) or 3 (memory-to-device done).
  - With `eng_err`: 4 or 5, for the same two directions in the same order.
  - A status read that finds a completion code returns that code and puts the status back to idle.
  - `eng_done` while not busy has no effect.
- R8: `irq` is high exactly while the status holds a completion code (2 to 5) and the interrupt-enable register is non-zero.
- R9: While busy, writes to the read/write registers and to the operation register are ignored, yet still answer write OK.
- R10: An address of 0x24 or above, or one not word aligned, gives the following responses.
  - A read returns data 0 with code 1.
  - A write returns code 3.
- R11: While a response is held with `rsp_ready` low, `req_ready` stays low and `rsp_rdata` and `rsp_code` stay unchanged.
- R12: A status read accepted in the same cycle as `eng_done` returns busy (1), and the completion code it misses stays in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | byte offset in the window |
| req_wdata | input | DATA_W | write data |
| rsp_valid | output | 1 | response held |
| rsp_ready | input | 1 | response consumed |
| rsp_rdata | output | DATA_W | read data |
| rsp_code | output | 2 | 0 read OK, 1 read error, 2 write OK, 3 write error |
| dev_blocks | input | DATA_W | device capacity in blocks |
| ext_base_hi | input | DATA_W | upper buffer address word |
| xfer_go | output | 1 | one-cycle launch pulse |
| xfer_to_mem | output | 1 | 1 device to memory, 0 memory to device |
| xfer_buf | output | 2*DATA_W | full buffer address |
| xfer_count | output | DATA_W | blocks to move |
| xfer_lba | output | DATA_W | first block index |
| eng_done | input | 1 | engine finished (one-cycle pulse) |
| eng_err | input | 1 | qualifies `eng_done` as failed |
| irq | output | 1 | completion interrupt |

## Verification
Two events can land in the same cycle: an accepted status read and the engine's `eng_done` pulse. The bench provokes this by raising the status-read request and `eng_done` on the same falling edge while the block is busy.

The rule for judging it:
- the response must carry busy;
- the interrupt must rise afterwards;
- a second status read must still find the completion code and only then return the block to idle.

The launch pulse is also checked against config writes made during the busy window.

// File: rtl/blkdev_pkg.sv
package blkdev_pkg;

  localparam int NUM_REGS = 9;
  localparam int SEL_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BUSY   = 3'd1,
    ST_RD_OK  = 3'd2,
    ST_WR_OK  = 3'd3,
    ST_RD_ERR = 3'd4,
    ST_WR_ERR = 3'd5
  } stat_e;

  typedef enum logic [1:0] {
    RSP_RD_OK  = 2'd0,
    RSP_RD_ERR = 2'd1,
    RSP_WR_OK  = 2'd2,
    RSP_WR_ERR = 2'd3
  } rsp_e;

  // Word index order is behaviour: it is the software offset map.
  typedef enum logic [SEL_W-1:0] {
    SEL_BUF_LO   = 4'd0,
    SEL_COUNT    = 4'd1,
    SEL_LBA      = 4'd2,
    SEL_OP       = 4'd3,
    SEL_STATUS   = 4'd4,
    SEL_IRQ_EN   = 4'd5,
    SEL_DEV_SIZE = 4'd6,
    SEL_BLK_SIZE = 4'd7,
    SEL_BUF_HI   = 4'd8,
    SEL_NONE     = 4'd15
  } sel_e;

  typedef struct packed {
    sel_e sel;
    logic rd_ok;
    logic wr_ok;
  } dec_t;

  localparam int OP_TO_MEM   = 1;
  localparam int OP_FROM_MEM = 2;

endpackage

// File: rtl/blkdev_decode.sv
module blkdev_decode
  import blkdev_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             in_win;

  assign idx    = addr[ADDR_W-1:2];
  assign in_win = (addr[1:0] == 2'b00) && (int'(idx) < NUM_REGS);

  always_comb begin
    dec.sel   = SEL_NONE;
    dec.rd_ok = 1'b0;
    dec.wr_ok = 1'b0;
    if (in_win) begin
      dec.sel   = sel_e'(idx[SEL_W-1:0]);
      dec.rd_ok = (dec.sel != SEL_OP);
      dec.wr_ok = (dec.sel == SEL_BUF_LO) || (dec.sel == SEL_COUNT) ||
                  (dec.sel == SEL_LBA)    || (dec.sel == SEL_IRQ_EN) ||
                  (dec.sel == SEL_OP);
    end
  end
endmodule

// File: rtl/blkdev_cfg.sv
module blkdev_cfg
  import blkdev_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hold,
  output logic [DATA_W-1:0] buf_lo,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] lba,
  output logic [DATA_W-1:0] irq_en
);
  localparam int NSLOT = 4;
  localparam sel_e SLOT_SEL [NSLOT] = '{SEL_BUF_LO, SEL_COUNT, SEL_LBA, SEL_IRQ_EN};

  logic [DATA_W-1:0] slot_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && !hold && (sel == SLOT_SEL[g]))
        slot_q[g] <= wdata;
    end
  end

  assign buf_lo = slot_q[0];
  assign count  = slot_q[1];
  assign lba    = slot_q[2];
  assign irq_en = slot_q[3];
endmodule

// File: rtl/blkdev_ctrl.sv
module blkdev_ctrl
  import blkdev_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_wr,
  input  logic [DATA_W-1:0] op_code,
  input  logic              stat_rd,
  input  logic              eng_done,
  input  logic              eng_err,
  output stat_e             stat,
  output logic              go,
  output logic              to_mem
);
  logic op_valid;
  assign op_valid = (op_code == DATA_W'(OP_TO_MEM)) || (op_code == DATA_W'(OP_FROM_MEM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat   <= ST_IDLE;
      go     <= 1'b0;
      to_mem <= 1'b0;
    end else begin
      go <= 1'b0;
      unique case (stat)
        ST_IDLE: begin
          if (op_wr && op_valid) begin
            stat   <= ST_BUSY;
            go     <= 1'b1;
            to_mem <= (op_code == DATA_W'(OP_TO_MEM));
          end
        end
        ST_BUSY: begin
          if (eng_done) begin
            if (to_mem) stat <= eng_err ? ST_RD_ERR : ST_RD_OK;
            else        stat <= eng_err ? ST_WR_ERR : ST_WR_OK;
          end
        end
        default: begin
          if (stat_rd) stat <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/blkdev_regs.sv
module blkdev_regs
  import blkdev_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int BLOCK_BYTES = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [1:0]          rsp_code,
  input  logic [DATA_W-1:0]   dev_blocks,
  input  logic [DATA_W-1:0]   ext_base_hi,
  output logic                xfer_go,
  output logic                xfer_to_mem,
  output logic [2*DATA_W-1:0] xfer_buf,
  output logic [DATA_W-1:0]   xfer_count,
  output logic [DATA_W-1:0]   xfer_lba,
  input  logic                eng_done,
  input  logic                eng_err,
  output logic                irq
);
  dec_t              dec;
  logic              acc;
  logic              wr_acc;
  logic              rd_acc;
  logic [DATA_W-1:0] buf_lo_q;
  logic [DATA_W-1:0] irq_en_q;
  logic [DATA_W-1:0] rd_mux;
  stat_e             stat_q;
  logic              busy;
  logic              done_state;

  assign req_ready = !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write && dec.wr_ok;
  assign rd_acc    = acc && !req_write && dec.rd_ok;
  assign busy      = (stat_q == ST_BUSY);
  assign done_state = (stat_q != ST_IDLE) && (stat_q != ST_BUSY);

  blkdev_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  blkdev_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_acc),
    .sel    (dec.sel),
    .wdata  (req_wdata),
    .hold   (busy),
    .buf_lo (buf_lo_q),
    .count  (xfer_count),
    .lba    (xfer_lba),
    .irq_en (irq_en_q)
  );

  blkdev_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_wr    (wr_acc && (dec.sel == SEL_OP)),
    .op_code  (req_wdata),
    .stat_rd  (rd_acc && (dec.sel == SEL_STATUS)),
    .eng_done (eng_done),
    .eng_err  (eng_err),
    .stat     (stat_q),
    .go       (xfer_go),
    .to_mem   (xfer_to_mem)
  );

  always_comb begin
    unique case (dec.sel)
      SEL_BUF_LO:   rd_mux = buf_lo_q;
      SEL_COUNT:    rd_mux = xfer_count;
      SEL_LBA:      rd_mux = xfer_lba;
      SEL_STATUS:   rd_mux = DATA_W'(stat_q);
      SEL_IRQ_EN:   rd_mux = irq_en_q;
      SEL_DEV_SIZE: rd_mux = dev_blocks;
      SEL_BLK_SIZE: rd_mux = DATA_W'(BLOCK_BYTES);
      SEL_BUF_HI:   rd_mux = ext_base_hi;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_code  <= RSP_RD_OK;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      if (req_write) begin
        rsp_rdata <= '0;
        rsp_code  <= dec.wr_ok ? RSP_WR_OK : RSP_WR_ERR;
      end else begin
        rsp_rdata <= dec.rd_ok ? rd_mux : '0;
        rsp_code  <= dec.rd_ok ? RSP_RD_OK : RSP_RD_ERR;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign xfer_buf = {ext_base_hi, buf_lo_q};
  assign irq      = done_state && (irq_en_q != '0);
endmodule

// File: rtl/blkdev_regs_chk.sv
module blkdev_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic [1:0]          rsp_code,
  input logic                xfer_go,
  input logic [2:0]          stat,
  input logic [2*DATA_W-1:0] xfer_buf,
  input logic [DATA_W-1:0]   xfer_count,
  input logic [DATA_W-1:0]   xfer_lba,
  input logic                irq
);
  p_go_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go);

  p_go_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> (stat == 3'd1));

  p_stat_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat <= 3'd5);

  p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat >= 3'd2 && stat <= 3'd5));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 3'd1) |=> ($stable(xfer_count) && $stable(xfer_lba) &&
                        $stable(xfer_buf[DATA_W-1:0])));

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_code)));

  p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind blkdev_regs blkdev_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .rsp_code   (rsp_code),
  .xfer_go    (xfer_go),
  .stat       (stat_q),
  .xfer_buf   (xfer_buf),
  .xfer_count (xfer_count),
  .xfer_lba   (xfer_lba),
  .irq        (irq)
);

// File: tb/tb_blkdev_regs.sv
`timescale 1ns/1ps
module tb_blkdev_regs;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int BB = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic [1:0]    rsp_code;
  logic [DW-1:0] dev_blocks = 32'h0001_2000;
  logic [DW-1:0] ext_base_hi = 32'h0000_0012;
  logic          xfer_go;
  logic          xfer_to_mem;
  logic [2*DW-1:0] xfer_buf;
  logic [DW-1:0] xfer_count;
  logic [DW-1:0] xfer_lba;
  logic          eng_done = 1'b0;
  logic          eng_err = 1'b0;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  blkdev_regs #(.DATA_W(DW), .ADDR_W(AW), .BLOCK_BYTES(BB)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_code(rsp_code),
    .dev_blocks(dev_blocks), .ext_base_hi(ext_base_hi),
    .xfer_go(xfer_go), .xfer_to_mem(xfer_to_mem), .xfer_buf(xfer_buf),
    .xfer_count(xfer_count), .xfer_lba(xfer_lba),
    .eng_done(eng_done), .eng_err(eng_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Returns at the falling edge right after acceptance; response is on the ports.
  task automatic bus(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] rd, output logic [1:0] code);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    code = rsp_code;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic [1:0] code);
    logic [DW-1:0] unused_rd;
    bus(1'b1, a, d, unused_rd, code);
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] rd, output logic [1:0] code);
    bus(1'b0, a, '0, rd, code);
  endtask

  task automatic engine_done(input logic e);
    @(negedge clk);
    eng_done = 1'b1; eng_err = e;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d; logic [1:0] c;
    chk("R1 irq", irq, 0);
    chk("R1 go", xfer_go, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    rd_reg(6'h10, d, c); chk("R1 status", d, 0);
    rd_reg(6'h04, d, c); chk("R1 count", d, 0);
    rd_reg(6'h14, d, c); chk("R1 irq_en", d, 0);
  endtask

  task automatic t_rw();
    logic [DW-1:0] d; logic [1:0] c;
    wr_reg(6'h00, 32'hCAFE_0040, c); chk("R2 wr code", c, 2);
    wr_reg(6'h04, 32'h0000_0003, c);
    wr_reg(6'h08, 32'h0000_0A5A, c);
    wr_reg(6'h14, 32'h0000_0001, c);
    rd_reg(6'h00, d, c); chk("R2 buf_lo", d, 32'hCAFE_0040); chk("R2 rd code", c, 0);
    rd_reg(6'h04, d, c); chk("R2 count", d, 3);
    rd_reg(6'h08, d, c); chk("R2 lba", d, 32'h0A5A);
    rd_reg(6'h14, d, c); chk("R2 irq_en", d, 1);
    chk("R6 xfer_buf", xfer_buf, 64'h0000_0012_CAFE_0040);
  endtask

  task automatic t_readonly();
    logic [DW-1:0] d; logic [1:0] c;
    rd_reg(6'h18, d, c); chk("R6 dev size", d, 32'h0001_2000);
    rd_reg(6'h1C, d, c); chk("R6 blk size", d, BB);
    rd_reg(6'h20, d, c); chk("R6 buf hi", d, 32'h12);
    wr_reg(6'h1C, 32'h7, c); chk("R5 wr blk size code", c, 3);
    rd_reg(6'h1C, d, c); chk("R5 blk size unchanged", d, BB);
    wr_reg(6'h10, 32'h1, c); chk("R5 wr status code", c, 3);
    rd_reg(6'h10, d, c); chk("R5 status unchanged", d, 0);
    wr_reg(6'h20, 32'h9, c); chk("R5 wr buf hi code", c, 3);
    rd_reg(6'h0C, d, c); chk("R4 op read data", d, 0); chk("R4 op read code", c, 1);
  endtask

  task automatic t_range();
    logic [DW-1:0] d; logic [1:0] c;
    rd_reg(6'h24, d, c); chk("R10 rd 0x24 code", c, 1); chk("R10 rd 0x24 data", d, 0);
    rd_reg(6'h02, d, c); chk("R10 rd unaligned code", c, 1);
    wr_reg(6'h3C, 32'h1, c); chk("R10 wr 0x3C code", c, 3);
    wr_reg(6'h05, 32'hFF, c); chk("R10 wr unaligned code", c, 3);
    rd_reg(6'h04, d, c); chk("R10 count untouched", d, 3);
  endtask

  task automatic t_ops();
    logic [DW-1:0] d; logic [1:0] c;
    wr_reg(6'h0C, 32'd0, c); chk("R3 op0 code", c, 2); chk("R3 op0 no go", xfer_go, 0);
    wr_reg(6'h0C, 32'd7, c); chk("R3 op7 no go", xfer_go, 0);
    rd_reg(6'h10, d, c); chk("R3 ignored op idle", d, 0);
    // device -> memory
    wr_reg(6'h0C, 32'd1, c);
    chk("R3 go high", xfer_go, 1); chk("R3 dir to_mem", xfer_to_mem, 1);
    @(negedge clk); chk("R3 go one cycle", xfer_go, 0);
    rd_reg(6'h10, d, c); chk("R3 busy", d, 1);
    wr_reg(6'h04, 32'h55, c); chk("R9 busy wr code", c, 2);
    rd_reg(6'h04, d, c); chk("R9 count kept", d, 3);
    wr_reg(6'h0C, 32'd2, c); chk("R9 op while busy no go", xfer_go, 0);
    chk("R8 irq low while busy", irq, 0);
    engine_done(1'b0);
    chk("R8 irq on completion", irq, 1);
    rd_reg(6'h10, d, c); chk("R7 read ok status", d, 2);
    chk("R8 irq cleared by status read", irq, 0);
    rd_reg(6'h10, d, c); chk("R7 back to idle", d, 0);
    engine_done(1'b0);
    rd_reg(6'h10, d, c); chk("R7 done while idle ignored", d, 0);
    // memory -> device with error, interrupt disabled
    wr_reg(6'h14, 32'd0, c);
    wr_reg(6'h0C, 32'd2, c);
    chk("R3 go high op2", xfer_go, 1); chk("R3 dir from mem", xfer_to_mem, 0);
    engine_done(1'b1);
    chk("R8 irq masked", irq, 0);
    rd_reg(6'h10, d, c); chk("R7 write error status", d, 5);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d; logic [1:0] c;
    wr_reg(6'h14, 32'h100, c);
    wr_reg(6'h0C, 32'd1, c);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h10;
    eng_done = 1'b1; eng_err = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; eng_done = 1'b0; eng_err = 1'b0;
    chk("R12 status read sees busy", rsp_rdata, 1);
    chk("R12 irq after collision", irq, 1);
    rd_reg(6'h10, d, c); chk("R12 completion kept", d, 4);
    rd_reg(6'h10, d, c); chk("R12 then idle", d, 0);
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] d0;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h08;
    @(negedge clk);
    req_valid = 1'b0;
    d0 = rsp_rdata;
    chk("R11 rsp data", d0, 32'h0A5A);
    repeat (3) @(negedge clk);
    chk("R11 held valid", rsp_valid, 1);
    chk("R11 held data", rsp_rdata, d0);
    chk("R11 req blocked", req_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", rsp_valid, 0);
    chk("R11 ready again", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rw();
    t_readonly();
    t_range();
    t_ops();
    t_collide();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule